// File: doc/BRIEF.md
# Multi-Level Sequential Trigger Unit

This block is the trigger engine of an on-chip logic analyzer. A bus of probed signals is sampled on one capture clock. For each trigger level, every signal carries its own condition code. The unit walks through the levels strictly in order. It raises a one-cycle trigger pulse when the last programmed level is satisfied. Each time any level is met, it also pulses a level-met flag and moves its level index forward.

A level runs in one of two modes:
- **Basic mode.** The level is met when all per-signal conditions of that level hold at the same time (logical AND).
- **Advanced mode.** Every signal whose code is not Don't Care feeds an either-edge detector. The detector outputs are ORed, so any change on one of those signals meets the level.

Edges are found by comparing the current sample with the previous one. The previous-sample register is loaded when the unit is armed, so a signal that is already static at arm time never gives a false edge.

Software arms the unit with a pulse. After that, `waiting` reads high until the trigger fires. With autorun set, the unit re-arms itself after every trigger. Configuration is expected to change only while the unit is idle.

Top module: `seq_trigger_unit`

## Requirements
- R1: While reset is held and right after it is released, `waiting`, `levelIdx`, `levelHit` and `trigPulse` are all zero.
- R2: A high `armReq` sampled on a clock edge makes `waiting` 1 and `levelIdx` 0 after that edge, with no level-met pulse. This also restarts a sequence that is already in progress.
- R3: Condition codes are 3 bits per signal per level, stored at `condCfg[(level*NUM_SIGS+signal)*3 +: 3]`. The codes are: 0 = Don't Care, 1 = High, 2 = Low, 3 = Rise, 4 = Fall, 5 = Either edge; 6 and 7 act as Don't Care. A basic-mode level is met only when every signal meets its code in the same sample.
- R4: Rise, Fall and Either compare each sample with the sample taken one capture clock earlier. The sample taken at the arm edge is the first reference, so a signal that stays constant across arming never meets an edge code.
- R5: Only the level at `levelIdx` is evaluated, and at most one level is met per cycle. A met level that is not the last one gives a one-cycle `levelHit` and raises `levelIdx` by one. A condition that belongs to a later level has no effect until that level is reached.
- R6: When the level equal to `lastLevel` is met, the unit gives a one-cycle `trigPulse` together with `levelHit`, and `levelIdx` returns to 0. Without autorun, `waiting` drops to 0 at the same time.
- R7: When `advMode[level]` is 1, that level is met when any signal with a non-Don't-Care code differs from its previous sample. Changes on Don't-Care signals are ignored, and a level with no selected signal is never met.
- R8: When `autoRun` is 1 at the cycle the last level is met, `waiting` stays 1 and the sequence starts again from level 0.
- R9: While `waiting` is 0 and no arm request is present, `levelHit` and `trigPulse` stay 0 whatever the probes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rstN | input | 1 | Active-low synchronous reset |
| probeIn | input | NUM_SIGS | Probed signals |
| armReq | input | 1 | Arm or restart the sequence |
| autoRun | input | 1 | Re-arm automatically after each trigger |
| lastLevel | input | LVL_W | Index of the final level |
| condCfg | input | NUM_LEVELS*NUM_SIGS*3 | Per-level, per-signal condition codes |
| advMode | input | NUM_LEVELS | Per-level advanced (OR of edges) select |
| waiting | output | 1 | Armed and waiting for the trigger |
| levelIdx | output | LVL_W | Level currently evaluated |
| levelHit | output | 1 | Pulse: a level was met |
| trigPulse | output | 1 | Pulse: final level met |

## Verification
The assertions check several rules on every cycle:
- After an arm, the unit is waiting at level 0.
- The level index only steps up by one or returns to zero.
- A trigger pulse always comes with a level-met pulse and an index of 0.
- An idle, unarmed unit never produces a hit.

Only the bench scenarios can show the following:
- The decoding of each condition code.
- The absence of a false edge at arm time.
- Out-of-order events being ignored.
- A restart in mid-sequence.
- Advanced-mode selection.
- Autorun re-arming.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

  typedef enum logic [2:0] {
    COND_ANY    = 3'd0,
    COND_HIGH   = 3'd1,
    COND_LOW    = 3'd2,
    COND_RISE   = 3'd3,
    COND_FALL   = 3'd4,
    COND_EITHER = 3'd5
  } cond_code_e;

  localparam int unsigned CODE_W = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleEn;  // update the previous-sample register
    logic evalEn;    // the selected level may be reported as met
  } trig_strobe_t;

endpackage

// File: rtl/trig_level_eval.sv
module trig_level_eval
  import seq_trig_pkg::*;
#(
  parameter int unsigned NUM_SIGS = 8
) (
  input  logic [NUM_SIGS*CODE_W-1:0] codes,
  input  logic                       advSel,
  input  logic [NUM_SIGS-1:0]        curSample,
  input  logic [NUM_SIGS-1:0]        prevSample,
  output logic                       levelMet
);

  logic [NUM_SIGS-1:0] sigOk;
  logic [NUM_SIGS-1:0] sigPick;

  for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig
    logic [CODE_W-1:0] code;
    logic cur, prev;
    assign code = codes[s*CODE_W +: CODE_W];
    assign cur  = curSample[s];
    assign prev = prevSample[s];

    always_comb begin
      sigPick[s] = 1'b1;
      case (code)
        COND_HIGH:   sigOk[s] = cur;
        COND_LOW:    sigOk[s] = ~cur;
        COND_RISE:   sigOk[s] = cur & ~prev;
        COND_FALL:   sigOk[s] = ~cur & prev;
        COND_EITHER: sigOk[s] = cur ^ prev;
        default: begin
          sigOk[s]   = 1'b1;
          sigPick[s] = 1'b0;
        end
      endcase
    end
  end

  logic anyChange;
  assign anyChange = |(sigPick & (curSample ^ prevSample));
  assign levelMet  = advSel ? anyChange : (&sigOk);

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import seq_trig_pkg::*;
#(
  parameter int unsigned NUM_SIGS   = 8,
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int unsigned CFG_W     = NUM_LEVELS * NUM_SIGS * CODE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  trig_strobe_t          strobes,
  input  logic [LVL_W-1:0]      levelSel,
  input  logic [NUM_SIGS-1:0]   probeIn,
  input  logic [CFG_W-1:0]      condCfg,
  input  logic [NUM_LEVELS-1:0] advMode,
  output logic                  selHit
);

  localparam int unsigned LVL_CFG_W = NUM_SIGS * CODE_W;

  logic [NUM_SIGS-1:0]   prevQ;
  logic [NUM_LEVELS-1:0] levelMatch;

  always_ff @(posedge clk) begin
    if (!rstN)                 prevQ <= '0;
    else if (strobes.sampleEn) prevQ <= probeIn;
  end

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    trig_level_eval #(.NUM_SIGS(NUM_SIGS)) u_eval (
      .codes      (condCfg[l*LVL_CFG_W +: LVL_CFG_W]),
      .advSel     (advMode[l]),
      .curSample  (probeIn),
      .prevSample (prevQ),
      .levelMet   (levelMatch[l])
    );
  end

  assign selHit = strobes.evalEn & levelMatch[levelSel];

endmodule

// File: rtl/trig_control.sv
module trig_control
  import seq_trig_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armReq,
  input  logic             autoRun,
  input  logic [LVL_W-1:0] lastLevel,
  input  logic             selHit,
  output trig_strobe_t     strobes,
  output logic [LVL_W-1:0] levelIdx,
  output logic             waiting,
  output logic             levelHit,
  output logic             trigPulse
);

  logic             armedQ;
  logic [LVL_W-1:0] idxQ;
  logic             hitQ;
  logic             trigQ;
  logic             finalLvl;

  assign finalLvl = (idxQ >= lastLevel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      idxQ   <= '0;
      hitQ   <= 1'b0;
      trigQ  <= 1'b0;
    end else begin
      hitQ  <= 1'b0;
      trigQ <= 1'b0;
      if (armReq) begin
        armedQ <= 1'b1;
        idxQ   <= '0;
      end else if (selHit) begin
        hitQ <= 1'b1;
        if (finalLvl) begin
          trigQ  <= 1'b1;
          idxQ   <= '0;
          armedQ <= autoRun;
        end else begin
          idxQ <= idxQ + LVL_W'(1);
        end
      end
    end
  end

  assign strobes.sampleEn = armReq | armedQ;
  assign strobes.evalEn   = armedQ & ~armReq;

  assign levelIdx  = idxQ;
  assign waiting   = armedQ;
  assign levelHit  = hitQ;
  assign trigPulse = trigQ;

endmodule

// File: rtl/seq_trigger_unit.sv
module seq_trigger_unit
  import seq_trig_pkg::*;
#(
  parameter int unsigned NUM_SIGS   = 8,
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int unsigned CFG_W     = NUM_LEVELS * NUM_SIGS * 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SIGS-1:0]   probeIn,
  input  logic                  armReq,
  input  logic                  autoRun,
  input  logic [LVL_W-1:0]      lastLevel,
  input  logic [CFG_W-1:0]      condCfg,
  input  logic [NUM_LEVELS-1:0] advMode,
  output logic                  waiting,
  output logic [LVL_W-1:0]      levelIdx,
  output logic                  levelHit,
  output logic                  trigPulse
);

  trig_strobe_t strobes;
  logic         selHit;

  trig_datapath #(.NUM_SIGS(NUM_SIGS), .NUM_LEVELS(NUM_LEVELS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .levelSel (levelIdx),
    .probeIn  (probeIn),
    .condCfg  (condCfg),
    .advMode  (advMode),
    .selHit   (selHit)
  );

  trig_control #(.NUM_LEVELS(NUM_LEVELS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .armReq    (armReq),
    .autoRun   (autoRun),
    .lastLevel (lastLevel),
    .selHit    (selHit),
    .strobes   (strobes),
    .levelIdx  (levelIdx),
    .waiting   (waiting),
    .levelHit  (levelHit),
    .trigPulse (trigPulse)
  );

endmodule

// File: rtl/seq_trigger_unit_chk.sv
module seq_trigger_unit_chk #(
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             armReq,
  input logic             waiting,
  input logic [LVL_W-1:0] levelIdx,
  input logic             levelHit,
  input logic             trigPulse
);

  // R2
  arm_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> (waiting && levelIdx == '0 && !levelHit && !trigPulse));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelIdx) |-> (levelIdx == $past(levelIdx) + LVL_W'(1) || levelIdx == '0));

  // R6
  trig_has_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (levelHit && levelIdx == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!waiting && !armReq) |=> (!levelHit && !trigPulse));

endmodule

bind seq_trigger_unit seq_trigger_unit_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .armReq    (armReq),
  .waiting   (waiting),
  .levelIdx  (levelIdx),
  .levelHit  (levelHit),
  .trigPulse (trigPulse)
);

// File: tb/seq_trigger_unit_tb.sv
module seq_trigger_unit_tb;

  localparam int NS = 8;
  localparam int NL = 4;
  localparam int LW = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NS-1:0]  probeIn = '0;
  logic           armReq = 1'b0;
  logic           autoRun = 1'b0;
  logic [LW-1:0]  lastLevel = '0;
  logic [NL*NS*3-1:0] condCfg = '0;
  logic [NL-1:0]  advMode = '0;
  logic           waiting;
  logic [LW-1:0]  levelIdx;
  logic           levelHit;
  logic           trigPulse;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  seq_trigger_unit #(.NUM_SIGS(NS), .NUM_LEVELS(NL)) u_dut (
    .clk(clk), .rstN(rstN), .probeIn(probeIn), .armReq(armReq),
    .autoRun(autoRun), .lastLevel(lastLevel), .condCfg(condCfg),
    .advMode(advMode), .waiting(waiting), .levelIdx(levelIdx),
    .levelHit(levelHit), .trigPulse(trigPulse)
  );

  // expected {waiting, levelIdx, levelHit, trigPulse} after the next edge
  typedef struct {
    logic [4:0] val;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  function automatic logic [4:0] obs();
    return {waiting, levelIdx, levelHit, trigPulse};
  endfunction

  // monitor: compare one item per clock edge, just after the edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nTests++;
      if (obs() !== e.val) begin
        nFail++;
        $display("FAIL %s: got w/idx/hit/trig=%b expected %b", e.tag, obs(), e.val);
      end
    end
  end

  // driver: apply inputs for the next edge and queue what it should produce
  task automatic step(input logic [NS-1:0] p, input logic arm,
                      input logic w, input logic [LW-1:0] idx,
                      input logic hit, input logic trg, input string tag);
    exp_t e;
    @(negedge clk);
    probeIn = p;
    armReq  = arm;
    e.val = {w, idx, hit, trg};
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic setCond(input int lvl, input int sig, input logic [2:0] code);
    condCfg[(lvl*NS + sig)*3 +: 3] = code;
  endtask

  task automatic clearCfg();
    @(negedge clk);
    armReq    = 1'b0;
    condCfg   = '0;
    advMode   = '0;
    autoRun   = 1'b0;
    lastLevel = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    nTests++;
    if (obs() !== 5'b0) begin
      nFail++;
      $display("FAIL R1 in reset: got %b expected %b", obs(), 5'b0);
    end
    rstN = 1'b1;
    @(negedge clk);
    nTests++;
    if (obs() !== 5'b0) begin
      nFail++;
      $display("FAIL R1 after reset: got %b expected %b", obs(), 5'b0);
    end

    // R3 basic AND of High on sig0 and Low on sig1
    clearCfg();
    setCond(0, 0, 3'd1);
    setCond(0, 1, 3'd2);
    step(8'h00, 1, 1, 0, 0, 0, "R2 arm");
    step(8'h03, 0, 1, 0, 0, 0, "R3 partial match");
    step(8'h01, 0, 0, 0, 1, 1, "R3 R6 full match");
    step(8'h01, 0, 0, 0, 0, 0, "R9 idle after trigger");
    step(8'h00, 0, 0, 0, 0, 0, "R9 idle");

    // R4 rise on sig2, high at arm time
    clearCfg();
    setCond(0, 2, 3'd3);
    step(8'h04, 1, 1, 0, 0, 0, "R2 arm");
    step(8'h04, 0, 1, 0, 0, 0, "R4 no false edge");
    step(8'h00, 0, 1, 0, 0, 0, "R4 falling ignored for rise");
    step(8'h04, 0, 0, 0, 1, 1, "R4 rise");

    // R4 fall on sig3
    clearCfg();
    setCond(0, 3, 3'd4);
    step(8'h08, 1, 1, 0, 0, 0, "R2 arm");
    step(8'h08, 0, 1, 0, 0, 0, "R4 static");
    step(8'h00, 0, 0, 0, 1, 1, "R4 fall");

    // R5 four levels of rising edges in order
    clearCfg();
    for (int l = 0; l < 4; l++) setCond(l, l, 3'd3);
    lastLevel = 2'd3;
    step(8'h00, 1, 1, 0, 0, 0, "R2 arm");
    step(8'h02, 0, 1, 0, 0, 0, "R5 out of order ignored");
    step(8'h03, 0, 1, 1, 1, 0, "R5 level0 met");
    step(8'h03, 0, 1, 1, 0, 0, "R5 earlier edge not kept");
    step(8'h01, 0, 1, 1, 0, 0, "R5 wrong edge");
    step(8'h03, 0, 1, 2, 1, 0, "R5 level1 met");
    step(8'h07, 0, 1, 3, 1, 0, "R5 level2 met");
    step(8'h0F, 0, 0, 0, 1, 1, "R6 final level");

    // R2 restart mid-sequence
    step(8'h00, 1, 1, 0, 0, 0, "R2 arm");
    step(8'h01, 0, 1, 1, 1, 0, "R5 level0 met");
    step(8'h01, 1, 1, 0, 0, 0, "R2 restart");
    step(8'h03, 0, 1, 0, 0, 0, "R2 back at level0");
    step(8'h02, 0, 1, 0, 0, 0, "R2 level0 waits");
    step(8'h03, 0, 1, 1, 1, 0, "R2 level0 met again");

    // R7 advanced OR of edges on sig0..2, with autorun R8
    clearCfg();
    advMode[0] = 1'b1;
    for (int s = 0; s < 3; s++) setCond(0, s, 3'd5);
    autoRun = 1'b1;
    step(8'hF0, 1, 1, 0, 0, 0, "R2 arm");
    step(8'h70, 0, 1, 0, 0, 0, "R7 unselected change");
    step(8'h72, 0, 1, 0, 1, 1, "R7 R8 change triggers");
    step(8'h72, 0, 1, 0, 0, 0, "R8 rearmed static");
    step(8'h76, 0, 1, 0, 1, 1, "R8 second trigger");
    @(negedge clk);
    autoRun = 1'b0;
    step(8'h74, 0, 0, 0, 1, 1, "R8 autorun off");

    // R7 advanced level with no selected signal never fires
    clearCfg();
    advMode[0] = 1'b1;
    step(8'h00, 1, 1, 0, 0, 0, "R2 arm");
    step(8'hFF, 0, 1, 0, 0, 0, "R7 nothing selected");
    step(8'h00, 0, 1, 0, 0, 0, "R7 nothing selected");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule